// File: doc/BRIEF.md
# GPIO Pad State Retention Controller

This block sets the output-enable, output-drive, input-enable, pull-enable and pull-up controls for every pad in a GPIO bank. It derives them from the device power state and from the configuration that firmware has programmed. The bank has three kinds of pin:

- ordinary digital pins in the switchable domain;
- mixed-signal pins that can be placed in analog or digital mode;
- one always-on wake-up pin.

The block also registers the pad input levels for firmware to read. An input whose buffer is off reads as zero.

A retention store keeps, for each retention-capable pad, the settings it had just before the device enters the ultra-low-power state. It drives those settings for as long as that state lasts, whatever firmware writes in the meantime. The wake-up pin is exempt and keeps following its live configuration. Analog mode on a mixed-signal pin overrides retention and keeps that pad fully off.

Pin indices: digital pins occupy 0..N_DIG-1, and mixed-signal pins occupy N_DIG..N_DIG+N_MIX-1. Analog-mode bit j belongs to pin N_DIG+j. The wake-up pin is the highest index, N_DIG+N_MIX.

Power-state codes: 0 = powered down, 1 = power-on reset, 2 = default (after reset, before programming), 3 = active, 4 = ultra-low-power. Codes 5 to 7 are unused.

In every requirement, the per-pin control tuple is written {oe, drv, ie, pe, pu}.

Top module: `pad_retention_ctrl`

## Requirements
- R1: With power-state code 0, or any unused code 5, 6 or 7, every pin (wake-up pin included) drives {0,0,0,0,0}, so the pad floats.
- R2: With code 1 (power-on reset), every pin drives {0,0,0,0,0}, except the wake-up pin, which drives {0,0,0,1,1} (pull-up on).
- R3: With code 2 (default), digital pins and the wake-up pin drive {0,0,1,1,1}. Mixed-signal pins are in analog mode and drive {0,0,0,0,0}.
- R4: With code 3 (active), each pin that is not in analog mode drives oe = fw_oe, drv = fw_oe AND fw_out, ie = NOT fw_oe, pe = fw_pull_en and pu = fw_pull_en AND fw_pull_up. pu is never 1 while pe is 0, in any state.
- R5: A mixed-signal pin whose analog-mode bit is 1 drives {0,0,0,0,0} in codes 3 and 4, whatever its other configuration or its retained value.
- R6: With code 4 (ultra-low-power), each digital pin, and each mixed-signal pin not in analog mode, drives the tuple it had in the last clock cycle before code 4 was entered. Firmware register changes during code 4 have no effect on these pins until the code changes.
- R7: The wake-up pin has no retention. In code 4 it drives the same function of its live firmware bits as in R4.
- R8: rd_data[i] equals pad_in[i] AND ie[i] from the previous clock cycle. It is therefore 0 one cycle after the input buffer is disabled.
- R9: While rst_n is low, rd_data is all zero and the retention store returns to the default tuple {0,0,1,1,1}. Code 4 entered straight from reset therefore drives that tuple on digital pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the retention store and input samples |
| pwr_state | input | 3 | Device power-state code |
| fw_oe | input | N_DIG+N_MIX+1 | Programmed output enable per pin |
| fw_out | input | N_DIG+N_MIX+1 | Programmed output value per pin |
| fw_pull_en | input | N_DIG+N_MIX+1 | Programmed pull-resistor enable per pin |
| fw_pull_up | input | N_DIG+N_MIX+1 | Programmed pull direction per pin (1 = up) |
| fw_analog | input | N_MIX | Analog-mode select per mixed-signal pin |
| pad_in | input | N_DIG+N_MIX+1 | Level seen at each pad |
| pad_oe | output | N_DIG+N_MIX+1 | Output driver enable per pad |
| pad_drv | output | N_DIG+N_MIX+1 | Output value per pad |
| pad_ie | output | N_DIG+N_MIX+1 | Input buffer enable per pad |
| pad_pe | output | N_DIG+N_MIX+1 | Pull-resistor enable per pad |
| pad_pu | output | N_DIG+N_MIX+1 | Pull direction per pad (1 = up) |
| rd_data | output | N_DIG+N_MIX+1 | Registered input value per pin |

## Verification
The bench attacks the boundary at entry to ultra-low-power. It changes firmware on the very cycle the state code becomes 4 and on every cycle afterwards. A store that captures one cycle late, or keeps loading during the state, shows the new values instead of the pre-entry ones.

It toggles analog mode while retention is held. A design that lets retention win would keep a mixed-signal driver alive in analog mode. In that state it also expects the wake-up pin to follow firmware, which a design that retains every pin would fail to do.

Unused codes, reset asserted while in ultra-low-power, and entry to code 4 directly from reset or from default are driven as well. A wrong decode or a wrong reset value of the store then shows up as a pad driving or pulling where it should float or keep its default pull-up.

// File: rtl/pad_ret_pkg.sv
package pad_ret_pkg;

  typedef enum logic [2:0] {
    PS_OFF   = 3'd0,
    PS_POR   = 3'd1,
    PS_DFLT  = 3'd2,
    PS_RUN   = 3'd3,
    PS_SLEEP = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    PIN_DIG  = 2'd0,
    PIN_MIX  = 2'd1,
    PIN_WAKE = 2'd2
  } pin_class_e;

  typedef struct packed {
    logic off;
    logic por;
    logic dflt;
    logic run;
    logic sleep;
  } pwr_flags_t;

  typedef struct packed {
    logic oe;
    logic drv;
    logic ie;
    logic pe;
    logic pu;
  } pad_ctl_t;

  localparam pad_ctl_t CTL_OFF  = '{oe: 1'b0, drv: 1'b0, ie: 1'b0, pe: 1'b0, pu: 1'b0};
  localparam pad_ctl_t CTL_DFLT = '{oe: 1'b0, drv: 1'b0, ie: 1'b1, pe: 1'b1, pu: 1'b1};
  localparam pad_ctl_t CTL_WPOR = '{oe: 1'b0, drv: 1'b0, ie: 1'b0, pe: 1'b1, pu: 1'b1};

  function automatic pin_class_e pin_class_of(int idx, int n_dig, int n_mix);
    if (idx < n_dig) return PIN_DIG;
    if (idx < n_dig + n_mix) return PIN_MIX;
    return PIN_WAKE;
  endfunction

  // Controls implied by the programmed registers in an active state.
  function automatic pad_ctl_t fw_ctl(logic oe, logic val, logic pe, logic up);
    pad_ctl_t c;
    c.oe  = oe;
    c.drv = oe & val;
    c.ie  = ~oe;
    c.pe  = pe;
    c.pu  = pe & up;
    return c;
  endfunction

  // Final per-pin selection by power state and pin class.
  function automatic pad_ctl_t state_ctl(pin_class_e cls, pwr_flags_t f, logic an,
                                         pad_ctl_t live, pad_ctl_t held);
    pad_ctl_t c;
    c = CTL_OFF;
    if (f.por) begin
      c = (cls == PIN_WAKE) ? CTL_WPOR : CTL_OFF;
    end else if (f.dflt) begin
      c = (cls == PIN_MIX) ? CTL_OFF : CTL_DFLT;
    end else if (f.run) begin
      c = an ? CTL_OFF : live;
    end else if (f.sleep) begin
      if (an) c = CTL_OFF;
      else if (cls == PIN_WAKE) c = live;
      else c = held;
    end
    return c;
  endfunction

endpackage

// File: rtl/pad_state_decode.sv
module pad_state_decode
  import pad_ret_pkg::*;
(
  input  logic [2:0] pwr_state,
  output pwr_flags_t flags
);

  always_comb begin
    flags = '0;
    case (pwr_state_e'(pwr_state))
      PS_POR:   flags.por   = 1'b1;
      PS_DFLT:  flags.dflt  = 1'b1;
      PS_RUN:   flags.run   = 1'b1;
      PS_SLEEP: flags.sleep = 1'b1;
      default:  flags.off   = 1'b1;
    endcase
  end

endmodule

// File: rtl/pad_ret_cell.sv
module pad_ret_cell
  import pad_ret_pkg::*;
#(
  parameter pin_class_e CLASS = PIN_DIG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_flags_t flags,
  input  logic       fw_oe,
  input  logic       fw_out,
  input  logic       fw_pe,
  input  logic       fw_pu,
  input  logic       analog,
  output pad_ctl_t   ctl,
  output logic       hold
);

  pad_ctl_t live;
  pad_ctl_t held_q;
  logic     an_eff;

  assign an_eff = (CLASS == PIN_MIX) && analog;
  assign live   = fw_ctl(fw_oe, fw_out, fw_pe, fw_pu);
  assign ctl    = state_ctl(CLASS, flags, an_eff, live, held_q);
  assign hold   = flags.sleep && (CLASS != PIN_WAKE);

  // Tracks the driven controls every cycle outside ultra-low-power and
  // freezes once that state is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= CTL_DFLT;
    end else if (!hold) begin
      held_q <= ctl;
    end
  end

endmodule

// File: rtl/pad_in_sampler.sv
module pad_in_sampler #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_in,
  input  logic [N-1:0] pad_ie,
  output logic [N-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= pad_in & pad_ie;
    end
  end

endmodule

// File: rtl/pad_retention_ctrl.sv
module pad_retention_ctrl
  import pad_ret_pkg::*;
#(
  parameter int N_DIG = 8,
  parameter int N_MIX = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             pwr_state,
  input  logic [N_DIG+N_MIX:0]   fw_oe,
  input  logic [N_DIG+N_MIX:0]   fw_out,
  input  logic [N_DIG+N_MIX:0]   fw_pull_en,
  input  logic [N_DIG+N_MIX:0]   fw_pull_up,
  input  logic [N_MIX-1:0]       fw_analog,
  input  logic [N_DIG+N_MIX:0]   pad_in,
  output logic [N_DIG+N_MIX:0]   pad_oe,
  output logic [N_DIG+N_MIX:0]   pad_drv,
  output logic [N_DIG+N_MIX:0]   pad_ie,
  output logic [N_DIG+N_MIX:0]   pad_pe,
  output logic [N_DIG+N_MIX:0]   pad_pu,
  output logic [N_DIG+N_MIX:0]   rd_data
);

  localparam int N_PIN = N_DIG + N_MIX + 1;

  pwr_flags_t       flags;
  pad_ctl_t         ctl_v  [N_PIN];
  logic [N_PIN-1:0] an_bit;
  logic [N_PIN-1:0] hold_v;
  logic             ret_active;

  pad_state_decode u_decode (
    .pwr_state (pwr_state),
    .flags     (flags)
  );

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    localparam pin_class_e CLS = pin_class_of(g, N_DIG, N_MIX);

    if (CLS == PIN_MIX) begin : g_an
      assign an_bit[g] = fw_analog[g-N_DIG];
    end else begin : g_noan
      assign an_bit[g] = 1'b0;
    end

    pad_ret_cell #(.CLASS(CLS)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags  (flags),
      .fw_oe  (fw_oe[g]),
      .fw_out (fw_out[g]),
      .fw_pe  (fw_pull_en[g]),
      .fw_pu  (fw_pull_up[g]),
      .analog (an_bit[g]),
      .ctl    (ctl_v[g]),
      .hold   (hold_v[g])
    );

    assign pad_oe[g]  = ctl_v[g].oe;
    assign pad_drv[g] = ctl_v[g].drv;
    assign pad_ie[g]  = ctl_v[g].ie;
    assign pad_pe[g]  = ctl_v[g].pe;
    assign pad_pu[g]  = ctl_v[g].pu;
  end

  // Named event for the checker: some pad is holding retained settings.
  assign ret_active = |hold_v;

  pad_in_sampler #(.N(N_PIN)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (pad_in),
    .pad_ie  (pad_ie),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/pad_retention_ctrl_chk.sv
module pad_retention_ctrl_chk #(
  parameter int N_DIG = 8,
  parameter int N_MIX = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           pwr_state,
  input logic [N_DIG+N_MIX:0] fw_oe,
  input logic [N_MIX-1:0]     fw_analog,
  input logic [N_DIG+N_MIX:0] pad_oe,
  input logic [N_DIG+N_MIX:0] pad_drv,
  input logic [N_DIG+N_MIX:0] pad_ie,
  input logic [N_DIG+N_MIX:0] pad_pe,
  input logic [N_DIG+N_MIX:0] pad_pu,
  input logic [N_DIG+N_MIX:0] rd_data,
  input logic                 ret_active
);

  localparam int NP = N_DIG + N_MIX + 1;
  localparam int WK = NP - 1;

  function automatic logic [NP-1:0] span(int lo, int hi);
    logic [NP-1:0] m;
    m = '0;
    for (int k = lo; k <= hi; k++) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [NP-1:0] DIG_M  = span(0, N_DIG - 1);
  localparam logic [NP-1:0] MIX_M  = span(N_DIG, N_DIG + N_MIX - 1);
  localparam logic [NP-1:0] WAKE_M = span(WK, WK);

  logic [NP-1:0] an_vec;
  always_comb begin
    an_vec = '0;
    for (int j = 0; j < N_MIX; j++) an_vec[N_DIG+j] = fw_analog[j];
  end

  assert_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 || pwr_state > 3'd4) |->
      ((pad_oe | pad_drv | pad_ie | pad_pe | pad_pu) == '0));

  assert_por_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd1) |->
      (pad_oe == '0 && pad_ie == '0 && pad_pe == WAKE_M && pad_pu == WAKE_M));

  assert_dflt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd2) |->
      (pad_oe == '0 && pad_ie == ~MIX_M && pad_pe == ~MIX_M && pad_pu == ~MIX_M));

  assert_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3) |->
      (((pad_oe ^ fw_oe) & ~an_vec) == '0 && ((pad_ie ^ ~fw_oe) & ~an_vec) == '0));

  assert_pull_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & ~pad_pe) == '0);

  assert_analog_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3 || pwr_state == 3'd4) |->
      (((pad_oe | pad_ie | pad_pe | pad_drv) & an_vec) == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_active && $past(ret_active)) |->
      ($stable(pad_oe & DIG_M) && $stable(pad_drv & DIG_M) && $stable(pad_ie & DIG_M)
       && $stable(pad_pe & DIG_M) && $stable(pad_pu & DIG_M)));

  assert_wake_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd4) |->
      (pad_oe[WK] == fw_oe[WK] && pad_ie[WK] == !fw_oe[WK]));

  assert_rd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & ~$past(pad_ie)) == '0));

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      assert_rd_reset_R9: assert (rd_data == '0);
    end
  end

endmodule

bind pad_retention_ctrl pad_retention_ctrl_chk #(.N_DIG(N_DIG), .N_MIX(N_MIX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_state  (pwr_state),
  .fw_oe      (fw_oe),
  .fw_analog  (fw_analog),
  .pad_oe     (pad_oe),
  .pad_drv    (pad_drv),
  .pad_ie     (pad_ie),
  .pad_pe     (pad_pe),
  .pad_pu     (pad_pu),
  .rd_data    (rd_data),
  .ret_active (ret_active)
);

// File: tb/pad_retention_ctrl_bench.sv
`timescale 1ns/1ps
module pad_retention_ctrl_bench;

  localparam int ND = 8;
  localparam int NM = 4;
  localparam int NP = ND + NM + 1;
  localparam int WK = NP - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    pwr_state = 3'd0;
  logic [NP-1:0] fw_oe = '0, fw_out = '0, fw_pull_en = '0, fw_pull_up = '0, pad_in = '0;
  logic [NM-1:0] fw_analog = '0;
  logic [NP-1:0] pad_oe, pad_drv, pad_ie, pad_pe, pad_pu, rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pad_retention_ctrl #(.N_DIG(ND), .N_MIX(NM)) u_pad_retention_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state),
    .fw_oe(fw_oe), .fw_out(fw_out), .fw_pull_en(fw_pull_en), .fw_pull_up(fw_pull_up),
    .fw_analog(fw_analog), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_drv(pad_drv), .pad_ie(pad_ie), .pad_pe(pad_pe), .pad_pu(pad_pu),
    .rd_data(rd_data)
  );

  // Reference model state: tuple bits are {oe, drv, ie, pe, pu}.
  logic [4:0]    ret_m [NP];
  logic [NP-1:0] rd_m;

  function automatic logic [4:0] expect_pin(int i, logic [2:0] st, logic [4:0] held);
    bit is_mix, is_wake, an;
    logic [4:0] act;
    is_mix  = (i >= ND) && (i < ND + NM);
    is_wake = (i == WK);
    an      = is_mix ? fw_analog[i-ND] : 1'b0;
    act     = {fw_oe[i], fw_oe[i] & fw_out[i], ~fw_oe[i], fw_pull_en[i],
               fw_pull_en[i] & fw_pull_up[i]};
    case (st)
      3'd1: return is_wake ? 5'b00011 : 5'b00000;
      3'd2: return is_mix ? 5'b00000 : 5'b00111;
      3'd3: return an ? 5'b00000 : act;
      3'd4: return is_wake ? act : (an ? 5'b00000 : held);
      default: return 5'b00000;
    endcase
  endfunction

  function automatic string tag_for(logic [2:0] st, logic rn);
    if (!rn) return "R9";
    case (st)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4/R5";
      3'd4: return "R6/R7/R5";
      default: return "R1";
    endcase
  endfunction

  always @(negedge rst_n) begin
    for (int i = 0; i < NP; i++) ret_m[i] = 5'b00111;
    rd_m = '0;
  end

  always @(posedge clk) begin
    logic [NP-1:0] rd_n;
    logic [4:0] e;
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) ret_m[i] = 5'b00111;
      rd_m = '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        e = expect_pin(i, pwr_state, ret_m[i]);
        rd_n[i] = pad_in[i] & e[2];
        if (pwr_state != 3'd4) ret_m[i] = e;
      end
      rd_m = rd_n;
    end
  end

  task automatic cmp(string tag, string name, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b", tag, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [NP-1:0] eo, ed, ei, ep, eu;
    logic [4:0] e;
    string t;
    if (!done) begin
      for (int i = 0; i < NP; i++) begin
        e = expect_pin(i, pwr_state, rst_n ? ret_m[i] : 5'b00111);
        {eo[i], ed[i], ei[i], ep[i], eu[i]} = e;
      end
      t = tag_for(pwr_state, rst_n);
      cmp(t, "pad_oe", pad_oe, eo);
      cmp(t, "pad_drv", pad_drv, ed);
      cmp(t, "pad_ie", pad_ie, ei);
      cmp(t, "pad_pe", pad_pe, ep);
      cmp(t, "pad_pu", pad_pu, eu);
      cmp(rst_n ? "R8" : "R9", "rd_data", rd_data, rd_m);
    end
  end

  always @(posedge clk) begin
    if (!done && cycles > 60000) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic scramble();
    fw_oe      = NP'($urandom);
    fw_out     = NP'($urandom);
    fw_pull_en = NP'($urandom);
    fw_pull_up = NP'($urandom);
    pad_in     = NP'($urandom);
  endtask

  // Advance n cycles; inputs change just after each rising edge.
  task automatic run(int n, logic [2:0] st, bit rnd_fw, bit rnd_an);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      pwr_state = st;
      if (rnd_fw) scramble();
      else pad_in = NP'($urandom);
      if (rnd_an) fw_analog = NM'($urandom);
    end
  endtask

  initial begin
    for (int i = 0; i < NP; i++) ret_m[i] = 5'b00111;
    rd_m = '0;
    pwr_state = 3'd4;
    scramble();
    // R9: reset held in ultra-low-power, then release straight into it.
    run(4, 3'd4, 1, 0);
    rst_n = 1'b1;
    run(10, 3'd4, 1, 1);
    // R1: powered down, then the unused codes.
    run(20, 3'd0, 1, 1);
    run(8, 3'd5, 1, 1);
    run(8, 3'd6, 1, 1);
    run(8, 3'd7, 1, 1);
    // R2, R3: power-on reset and default phases.
    run(20, 3'd1, 1, 1);
    run(20, 3'd2, 1, 1);
    // R6: enter ultra-low-power straight from default.
    run(15, 3'd4, 1, 1);
    // R4, R5: active with changing firmware and analog modes.
    run(200, 3'd3, 1, 1);
    // R6, R7, R5: retention under firmware churn, repeated entries.
    for (int r = 0; r < 40; r++) begin
      run(7, 3'd3, 1, 1);
      run(9, 3'd4, 1, 1);
    end
    // Analog held fixed across a retention window.
    fw_analog = '0;
    run(10, 3'd3, 1, 0);
    run(10, 3'd4, 1, 0);
    // R9: reset pulse during ultra-low-power.
    @(posedge clk); #1; rst_n = 1'b0;
    run(3, 3'd4, 1, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    run(10, 3'd4, 1, 1);
    run(20, 3'd3, 1, 1);
    run(5, 3'd0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule